// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms the data-memory address for the load and store operations of an 8-bit processor core. The decoder presents an operation code, a pointer selector and the current 16-bit value of the chosen pointer (X, Y or Z) with a single-cycle `start` pulse. The block then runs the access over its cycles. It drives the effective address, a one-cycle read, write or program-read strobe, and a write-back word for the pointer register file. The last cycle of every access is marked by `done`.

Pointers can be used as they are, incremented after the access, or decremented before it. Y and Z also accept a 6-bit unsigned displacement. A direct mode takes a 16-bit immediate address. Program-memory reads go through Z, with an optional increment after the read. A word register move hands a 16-bit register pair value to the write-back port in a single cycle. The register file, the memories and the decoder sit outside the block. All pointer arithmetic wraps modulo 2^16.

Top module: `ptrAddrGen`

## Requirements
- R1: After reset, and whenever no access is running, `busy`, `done`, `dataRd`, `dataWr`, `progRd` and `wbEn` are low and `memAddr` and `wbValue` are zero.
- R2: Mode 0 (plain indirect) runs for two cycles. In the first cycle it shows `memAddr` equal to the pointer with the data strobe. In the second cycle it raises `done`. It never raises `wbEn`.
- R3: Mode 1 (post-increment) uses the unchanged pointer as `memAddr`. It raises `wbEn` in the second cycle, together with `done`, with `wbValue` = pointer + 1 mod 2^16.
- R4: Mode 2 (pre-decrement) uses pointer − 1 mod 2^16 as `memAddr`. It raises `wbEn` in the first cycle, alongside the data strobe, with that same value.
- R5: Mode 3 (displacement) with selector 1 (Y) or 2 (Z) addresses pointer + `disp` (0..63) mod 2^16. It takes two cycles and gives no write-back.
- R6: An invalid request is ignored and the block stays idle. Invalid means mode 3 with selector 0 (X) or 3, or modes 0 to 2 with selector 3.
- R7: Mode 4 (direct) uses `immAddr` as `memAddr` and ignores `ptrVal`. It takes two cycles.
- R8: Mode 5 (program read) and mode 6 (program read with increment) pulse `progRd` in the first cycle with `memAddr` equal to the Z value given on `ptrVal`, and raise `done` in the third cycle. Mode 6 also raises `wbEn` in the third cycle with Z + 1 mod 2^16.
- R9: Mode 7 (word move) takes one cycle. In that cycle `wbEn` and `done` are high, `wbValue` equals `srcWord`, no strobe is raised and `memAddr` is zero.
- R10: `start` and every other request input are ignored while `busy` is high. The running access finishes with the values captured at its start.
- R11: In modes 0 to 4, `isStore` high selects `dataWr` in place of `dataRd`. In modes 5 to 7, `isStore` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| mode | input | 3 | Operation code 0..7 |
| ptrSel | input | 2 | Pointer selector: 0 X, 1 Y, 2 Z, 3 none |
| isStore | input | 1 | Store instead of load (modes 0 to 4) |
| ptrVal | input | 16 | Current value of the selected pointer |
| disp | input | 6 | Unsigned displacement |
| immAddr | input | 16 | Direct address |
| srcWord | input | 16 | Source register pair for the word move |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of the access |
| dataRd | output | 1 | Data-memory read strobe |
| dataWr | output | 1 | Data-memory write strobe |
| progRd | output | 1 | Program-memory read strobe |
| wbEn | output | 1 | Pointer or pair write-back enable |
| memAddr | output | 16 | Effective address, zero when idle |
| wbValue | output | 16 | Write-back word, zero when `wbEn` is low |

## Verification
A wrong captured address or write-back value shows on `memAddr` or `wbValue` in the first cycle after `start` is taken. A phase counter that skips or sticks moves `done`, `wbEn` or a strobe by one cycle, or leaves `busy` high past the expected length, and this is visible within three cycles. A mode latch that changes during an access alters the strobes or the address in the cycle right after the change. This is why the bench toggles the request inputs while the block is busy.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [2:0] {
    MD_PLAIN   = 3'd0,
    MD_POSTINC = 3'd1,
    MD_PREDEC  = 3'd2,
    MD_DISP    = 3'd3,
    MD_DIRECT  = 3'd4,
    MD_PROG    = 3'd5,
    MD_PROGINC = 3'd6,
    MD_MOVW    = 3'd7
  } accMode_t;

  typedef struct packed {
    logic capture;    // latch address and write-back word
    logic driveAddr;  // present the latched address on the port
  } pathCtl_t;
endpackage

// File: rtl/ptrCtl.sv
module ptrCtl
  import ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  accMode_t   mode,
  input  logic [1:0] ptrSel,
  input  logic       isStore,
  output pathCtl_t   ctl,
  output logic       busy,
  output logic       done,
  output logic       dataRd,
  output logic       dataWr,
  output logic       progRd,
  output logic       wbEn
);
  localparam int PhW = 2;

  logic [PhW-1:0] phase;
  logic [PhW-1:0] lastPh;
  accMode_t       modeQ;
  logic           storeQ;
  logic           legal;
  logic           isData;

  always_comb begin
    unique case (mode)
      MD_PLAIN, MD_POSTINC, MD_PREDEC: legal = (ptrSel != 2'd3);
      MD_DISP:                         legal = (ptrSel == 2'd1) || (ptrSel == 2'd2);
      default:                         legal = 1'b1;
    endcase
  end

  always_comb begin
    unique case (modeQ)
      MD_MOVW:             lastPh = PhW'(1);
      MD_PROG, MD_PROGINC: lastPh = PhW'(3);
      default:             lastPh = PhW'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= '0;
      modeQ  <= MD_PLAIN;
      storeQ <= 1'b0;
    end else if (phase == '0) begin
      if (start && legal) begin
        phase  <= PhW'(1);
        modeQ  <= mode;
        storeQ <= isStore;
      end
    end else if (phase == lastPh) begin
      phase <= '0;
    end else begin
      phase <= phase + PhW'(1);
    end
  end

  assign busy   = (phase != '0);
  assign done   = busy && (phase == lastPh);
  assign isData = (modeQ == MD_PLAIN) || (modeQ == MD_POSTINC) || (modeQ == MD_PREDEC)
               || (modeQ == MD_DISP) || (modeQ == MD_DIRECT);
  assign dataRd = (phase == PhW'(1)) && isData && !storeQ;
  assign dataWr = (phase == PhW'(1)) && isData && storeQ;
  assign progRd = (phase == PhW'(1)) && ((modeQ == MD_PROG) || (modeQ == MD_PROGINC));
  assign wbEn   = ((modeQ == MD_PREDEC)  && (phase == PhW'(1)))
               || ((modeQ == MD_POSTINC) && (phase == PhW'(2)))
               || ((modeQ == MD_PROGINC) && (phase == PhW'(3)))
               || ((modeQ == MD_MOVW)    && (phase == PhW'(1)));

  assign ctl.capture   = (phase == '0) && start && legal;
  assign ctl.driveAddr = busy && (modeQ != MD_MOVW);

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataRd, dataWr, progRd})); // R11
  AST_DATA_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd || dataWr) |=> done); // R2
  AST_PROG_THREE: assert property (@(posedge clk) disable iff (!rstN)
    progRd |=> (busy && !done)); // R8
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(modeQ)); // R10
endmodule

// File: rtl/ptrPath.sv
module ptrPath
  import ptr_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int DispW = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         ctl,
  input  accMode_t         mode,
  input  logic [AddrW-1:0] ptrVal,
  input  logic [DispW-1:0] disp,
  input  logic [AddrW-1:0] immAddr,
  input  logic [AddrW-1:0] srcWord,
  output logic [AddrW-1:0] memAddr,
  output logic [AddrW-1:0] wbWord
);
  localparam int PadW = AddrW - DispW;

  logic [AddrW-1:0] ptrInc, ptrDec, ptrOff;
  logic [AddrW-1:0] effNext, wbNext;
  logic [AddrW-1:0] effQ;

  assign ptrInc = ptrVal + AddrW'(1);
  assign ptrDec = ptrVal - AddrW'(1);
  assign ptrOff = ptrVal + {{PadW{1'b0}}, disp};

  always_comb begin
    unique case (mode)
      MD_PREDEC: effNext = ptrDec;
      MD_DISP:   effNext = ptrOff;
      MD_DIRECT: effNext = immAddr;
      MD_MOVW:   effNext = '0;
      default:   effNext = ptrVal;
    endcase
    unique case (mode)
      MD_POSTINC, MD_PROGINC: wbNext = ptrInc;
      MD_PREDEC:              wbNext = ptrDec;
      MD_MOVW:                wbNext = srcWord;
      default:                wbNext = ptrVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effQ   <= '0;
      wbWord <= '0;
    end else if (ctl.capture) begin
      effQ   <= effNext;
      wbWord <= wbNext;
    end
  end

  assign memAddr = ctl.driveAddr ? effQ : '0;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.driveAddr |=> (!ctl.driveAddr || $stable(memAddr))); // R10
endmodule

// File: rtl/ptrAddrGen.sv
module ptrAddrGen
  import ptr_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int DispW = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic [1:0]       ptrSel,
  input  logic             isStore,
  input  logic [AddrW-1:0] ptrVal,
  input  logic [DispW-1:0] disp,
  input  logic [AddrW-1:0] immAddr,
  input  logic [AddrW-1:0] srcWord,
  output logic             busy,
  output logic             done,
  output logic             dataRd,
  output logic             dataWr,
  output logic             progRd,
  output logic             wbEn,
  output logic [AddrW-1:0] memAddr,
  output logic [AddrW-1:0] wbValue
);
  pathCtl_t         ctl;
  accMode_t         modeIn;
  logic [AddrW-1:0] wbWord;

  assign modeIn = accMode_t'(mode);

  ptrCtl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .mode(modeIn), .ptrSel(ptrSel),
    .isStore(isStore), .ctl(ctl), .busy(busy), .done(done), .dataRd(dataRd),
    .dataWr(dataWr), .progRd(progRd), .wbEn(wbEn)
  );

  ptrPath #(.AddrW(AddrW), .DispW(DispW)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode(modeIn), .ptrVal(ptrVal),
    .disp(disp), .immAddr(immAddr), .srcWord(srcWord), .memAddr(memAddr),
    .wbWord(wbWord)
  );

  assign wbValue = wbEn ? wbWord : '0;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memAddr == '0 && wbValue == '0 && !wbEn)); // R1
  AST_PREDEC_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && (dataRd || dataWr)) |-> (wbValue == memAddr)); // R4
endmodule

// File: tb/sim_ptrAddrGen.sv
module sim_ptrAddrGen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, start, isStore;
  logic [2:0] mode;
  logic [1:0] ptrSel;
  logic [15:0] ptrVal, immAddr, srcWord;
  logic [5:0] disp;
  logic busy, done, dataRd, dataWr, progRd, wbEn;
  logic [15:0] memAddr, wbValue;
  int total = 0, bad = 0;

  ptrAddrGen u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .ptrSel(ptrSel),
    .isStore(isStore), .ptrVal(ptrVal), .disp(disp), .immAddr(immAddr),
    .srcWord(srcWord), .busy(busy), .done(done), .dataRd(dataRd),
    .dataWr(dataWr), .progRd(progRd), .wbEn(wbEn), .memAddr(memAddr),
    .wbValue(wbValue)
  );

  task automatic check(string tag, logic [37:0] exp);
    logic [37:0] act;
    act = {busy, done, dataRd, dataWr, progRd, wbEn, memAddr, wbValue};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ptrPick(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      default: return 16'h3C5A;
    endcase
  endfunction

  task automatic runOp(int m, int sel, bit st, logic [15:0] p, logic [5:0] q,
                       logic [15:0] k, logic [15:0] src, bit glitch);
    bit legal;
    int last;
    string tag;
    logic [15:0] ea, wv;
    bit rd, wr, prd, wb;
    @(negedge clk);
    mode = 3'(m); ptrSel = 2'(sel); isStore = st; ptrVal = p;
    disp = q; immAddr = k; srcWord = src; start = 1'b1;
    legal = 1'b1;
    if (m <= 2 && sel == 3) legal = 1'b0;
    if (m == 3 && !(sel == 1 || sel == 2)) legal = 1'b0;
    last = (m == 7) ? 1 : ((m == 5 || m == 6) ? 3 : 2);
    case (m)
      0: tag = st ? "R11" : "R2";
      1: tag = "R3";
      2: tag = "R4";
      3: tag = "R5";
      4: tag = "R7";
      5, 6: tag = st ? "R11" : "R8";
      default: tag = st ? "R11" : "R9";
    endcase
    if (!legal) tag = "R6";
    if (glitch) tag = "R10";
    @(negedge clk);
    if (!legal) begin
      start = 1'b0;
      check(tag, 38'd0);
      return;
    end
    case (m)
      2: ea = p - 16'd1;
      3: ea = p + {10'd0, q};
      4: ea = k;
      7: ea = 16'd0;
      default: ea = p;
    endcase
    for (int ph = 1; ph <= last; ph++) begin
      if (ph > 1) @(negedge clk);
      rd  = (ph == 1) && (m <= 4) && !st;
      wr  = (ph == 1) && (m <= 4) && st;
      prd = (ph == 1) && (m == 5 || m == 6);
      wb  = (m == 2 && ph == 1) || (m == 1 && ph == 2) || (m == 6 && ph == 3) || (m == 7 && ph == 1);
      if (!wb) wv = 16'd0;
      else if (m == 7) wv = src;
      else if (m == 2) wv = p - 16'd1;
      else wv = p + 16'd1;
      check(tag, {1'b1, (ph == last), rd, wr, prd, wb, ea, wv});
      if (glitch && ph < last) begin
        start = 1'b1; mode = 3'd7; ptrSel = 2'd0; isStore = ~st;
        ptrVal = ~p; immAddr = ~k; srcWord = ~src; disp = ~q;
      end else begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    check(tag, 38'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; mode = '0; ptrSel = '0; isStore = 1'b0;
    ptrVal = '0; disp = '0; immAddr = '0; srcWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 38'd0);
    for (int m = 0; m < 8; m++)
      for (int sel = 0; sel < 4; sel++)
        for (int st = 0; st < 2; st++)
          for (int pi = 0; pi < 5; pi++)
            for (int qi = 0; qi < 3; qi++) begin
              logic [15:0] p;
              logic [5:0] q;
              p = ptrPick(pi);
              q = (qi == 0) ? 6'd0 : ((qi == 1) ? 6'd1 : 6'd63);
              runOp(m, sel, st[0], p, q, ~p + 16'(qi * 257), p ^ 16'hA5C3, pi == 2);
            end
    // R1: idle state after all traffic
    @(negedge clk);
    check("R1", 38'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule